// File: doc/BRIEF.md
# Sharing-Aware Cache Bypass Controller

This block sits at the home node of a multi-node system whose nodes each put a large DRAM cache between their L3 and main memory. It learns at run time which lines are read-write shared. It then keeps those lines out of the DRAM caches, so that any forwarded read for such a line is served from an L3 and never waits on a slow DRAM-cache access.

The block has two independent channels. The lookup channel takes one coherence operation per directory lookup, together with the stored read-write-shared bit of that entry. It returns the updated bit for write-back, a request to invalidate DRAM-cache copies when the bit first becomes set, and the bypass flag that travels with returned data. The requester channel takes local L4 misses and L3 dirty evictions, each carrying the bypass bit the line got with its data. For each one it returns the DRAM-cache action. Each channel registers its input on a valid/ready handshake and produces its result combinationally from that register in the following cycle.

Top module: `share_bypass_ctl`

## Requirements
- R1: After reset, `rsp_valid` and `dc_valid` are 0 and both `lk_ready` and `rq_ready` are 1.
- R2: A lookup whose operation is a request-for-data forward (`lk_op`=1), an invalidate (`lk_op`=2) or a flush (`lk_op`=3) returns `rsp_rws`=1.
- R3: A plain memory read (`lk_op`=0) on an existing entry returns `rsp_rws` equal to the stored `lk_rws` and never sets it.
- R4: When `lk_new`=1 the stored bit is ignored and treated as clear, so a memory read on a new entry returns `rsp_rws`=0.
- R5: Operations 0 and 1 return data (`rsp_data`=1) with `rsp_byp` equal to the resulting `rsp_rws`. Operations 2 and 3 return `rsp_data`=0 and `rsp_byp`=0.
- R6: `rsp_inv_dc` is 1 exactly when the bit goes from clear to set on this lookup and `lk_dc_copy`=1.
- R7: An L4 miss (`rq_kind`=0) gives `dc_act`=1 (skip the DRAM cache, L3 only) when `rq_byp`=1, else `dc_act`=0 (fill the DRAM cache).
- R8: An L3 dirty eviction (`rq_kind`=1) gives `dc_act`=2 (write memory past the DRAM cache) when `rq_byp`=1, else `dc_act`=3 (write into the DRAM cache).
- R9: A transfer accepted at a clock edge appears at the output after that edge. While the output is valid and not ready it stays stable and the input side is not ready. When the output is taken in the same cycle, a new input is accepted without a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Directory lookup offered |
| lk_ready | output | 1 | Lookup accepted this cycle |
| lk_op | input | 2 | 0 memory read, 1 request-for-data, 2 invalidate, 3 flush |
| lk_idx | input | IDX_W | Directory entry index |
| lk_new | input | 1 | Entry freshly allocated |
| lk_rws | input | 1 | Stored read-write-shared bit |
| lk_dc_copy | input | 1 | DRAM-cache copies of the line exist |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Lookup result taken |
| rsp_idx | output | IDX_W | Entry index of the result |
| rsp_data | output | 1 | Result carries data to the requester |
| rsp_byp | output | 1 | Bypass flag sent with the data |
| rsp_rws | output | 1 | Bit to write back to the entry |
| rsp_inv_dc | output | 1 | Invalidate DRAM-cache copies |
| rq_valid | input | 1 | Local request offered |
| rq_ready | output | 1 | Local request accepted |
| rq_kind | input | 1 | 0 L4 miss fill, 1 L3 dirty eviction |
| rq_byp | input | 1 | Bypass bit of the line |
| rq_tag | input | TAG_W | Request tag |
| dc_valid | output | 1 | Decision valid |
| dc_ready | input | 1 | Decision taken |
| dc_tag | output | TAG_W | Tag of the decision |
| dc_act | output | 2 | 0 fill, 1 skip, 2 write memory, 3 write DRAM cache |

## Verification
The directory learning path and the requester decision path can both accept and both produce results in the same cycle. The bench provokes this by offering a sharing-setting lookup and an eviction with the bypass bit on the same edge. It judges both outputs at the next sampling point against values computed separately for each channel. It also holds the lookup result stalled while a second lookup waits. It checks that the stalled result does not change and that the second lookup then arrives intact.

// File: rtl/share_bypass_ctl.sv
module share_bypass_ctl #(
  parameter int IDX_W = 12,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [1:0]       lk_op,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic             lk_new,
  input  logic             lk_rws,
  input  logic             lk_dc_copy,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [IDX_W-1:0] rsp_idx,
  output logic             rsp_data,
  output logic             rsp_byp,
  output logic             rsp_rws,
  output logic             rsp_inv_dc,
  input  logic             rq_valid,
  output logic             rq_ready,
  input  logic             rq_kind,
  input  logic             rq_byp,
  input  logic [TAG_W-1:0] rq_tag,
  output logic             dc_valid,
  input  logic             dc_ready,
  output logic [TAG_W-1:0] dc_tag,
  output logic [1:0]       dc_act
);
  localparam logic [1:0] OP_MEMRD = 2'd0;
  localparam logic [1:0] OP_RFD   = 2'd1;
  localparam logic [1:0] ACT_FILL = 2'd0;
  localparam logic [1:0] ACT_SKIP = 2'd1;
  localparam logic [1:0] ACT_MEM  = 2'd2;
  localparam logic [1:0] ACT_DC   = 2'd3;

  logic             lk_full, new_q, rws_q, copy_q;
  logic [1:0]       op_q;
  logic [IDX_W-1:0] idx_q;
  logic             rq_full, kind_q, byp_q;
  logic [TAG_W-1:0] tag_q;
  logic             old_rws, learn, nxt_rws;

  assign lk_ready = !lk_full || rsp_ready;
  assign rq_ready = !rq_full || dc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_full <= 1'b0;
      rq_full <= 1'b0;
    end else begin
      if (lk_ready) lk_full <= lk_valid;
      if (rq_ready) rq_full <= rq_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid && lk_ready) begin
      op_q   <= lk_op;
      idx_q  <= lk_idx;
      new_q  <= lk_new;
      rws_q  <= lk_rws;
      copy_q <= lk_dc_copy;
    end
    if (rq_valid && rq_ready) begin
      kind_q <= rq_kind;
      byp_q  <= rq_byp;
      tag_q  <= rq_tag;
    end
  end

  assign old_rws = rws_q && !new_q;
  assign learn   = (op_q != OP_MEMRD);
  assign nxt_rws = old_rws || learn;

  assign rsp_valid  = lk_full;
  assign rsp_idx    = idx_q;
  assign rsp_rws    = nxt_rws;
  assign rsp_data   = (op_q == OP_MEMRD) || (op_q == OP_RFD);
  assign rsp_byp    = rsp_data && nxt_rws;
  assign rsp_inv_dc = lk_full && learn && !old_rws && copy_q;

  assign dc_valid = rq_full;
  assign dc_tag   = tag_q;
  always_comb begin
    if (!kind_q) dc_act = byp_q ? ACT_SKIP : ACT_FILL;
    else         dc_act = byp_q ? ACT_MEM  : ACT_DC;
  end
endmodule

// File: rtl/share_bypass_chk.sv
module share_bypass_chk #(
  parameter int IDX_W = 12,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic [1:0]       lk_op,
  input logic             lk_new,
  input logic             lk_rws,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [IDX_W-1:0] rsp_idx,
  input logic             rsp_byp,
  input logic             rsp_rws,
  input logic             rsp_inv_dc,
  input logic             rq_valid,
  input logic             rq_ready,
  input logic             rq_kind,
  input logic             rq_byp,
  input logic             dc_valid,
  input logic             dc_ready,
  input logic [TAG_W-1:0] dc_tag,
  input logic [1:0]       dc_act
);
  AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !rsp_valid && !dc_valid); // R1
  AST_LEARN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && lk_op != 2'd0 |=> rsp_valid && rsp_rws); // R2
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && lk_op == 2'd0 && (lk_new || !lk_rws) |=> !rsp_rws && !rsp_byp); // R3
  AST_FWD_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && lk_op == 2'd1 |=> rsp_byp); // R5
  AST_NO_REINV: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && lk_rws && !lk_new |=> !rsp_inv_dc); // R6
  AST_MISS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_ready && !rq_kind |=> dc_act == {1'b0, $past(rq_byp)}); // R7
  AST_EVICT_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_ready && rq_kind && rq_byp |=> dc_act == 2'd2); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_idx) && $stable(rsp_rws) && $stable(rsp_byp)); // R9
  AST_DC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dc_valid && !dc_ready |=> dc_valid && $stable(dc_tag) && $stable(dc_act)); // R9
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !lk_ready); // R9
endmodule

bind share_bypass_ctl share_bypass_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_op(lk_op),
  .lk_new(lk_new), .lk_rws(lk_rws), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_idx(rsp_idx), .rsp_byp(rsp_byp), .rsp_rws(rsp_rws), .rsp_inv_dc(rsp_inv_dc),
  .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_kind(rq_kind), .rq_byp(rq_byp),
  .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_tag(dc_tag), .dc_act(dc_act)
);

// File: tb/share_bypass_ctl_test.sv
module share_bypass_ctl_test;
  localparam int IDX_W = 12;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_new = 1'b0, lk_rws = 1'b0, lk_dc_copy = 1'b0;
  logic [1:0] lk_op = 2'd0;
  logic [IDX_W-1:0] lk_idx = '0;
  logic rsp_ready = 1'b1, rq_valid = 1'b0, rq_kind = 1'b0, rq_byp = 1'b0, dc_ready = 1'b1;
  logic [TAG_W-1:0] rq_tag = '0;
  logic lk_ready, rsp_valid, rsp_data, rsp_byp, rsp_rws, rsp_inv_dc, rq_ready, dc_valid;
  logic [IDX_W-1:0] rsp_idx;
  logic [TAG_W-1:0] dc_tag;
  logic [1:0] dc_act;

  int checks = 0;
  int fails = 0;

  always #2.5ns clk = ~clk;

  share_bypass_ctl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) uut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_lk(input string req, input int idx, input logic [1:0] op, input logic nw,
                       input logic rws, input logic cp, input logic e_data, input logic e_byp,
                       input logic e_rws, input logic e_inv);
    @(negedge clk);
    lk_valid = 1'b1; lk_op = op; lk_idx = idx[IDX_W-1:0]; lk_new = nw; lk_rws = rws; lk_dc_copy = cp;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(req, "rsp_valid", int'(rsp_valid), 1);
    chk(req, "rsp_idx", int'(rsp_idx), idx);
    chk(req, "rsp_data", int'(rsp_data), int'(e_data));
    chk(req, "rsp_byp", int'(rsp_byp), int'(e_byp));
    chk(req, "rsp_rws", int'(rsp_rws), int'(e_rws));
    chk(req, "rsp_inv_dc", int'(rsp_inv_dc), int'(e_inv));
  endtask

  task automatic do_rq(input string req, input int tag, input logic kind, input logic byp,
                       input int e_act);
    @(negedge clk);
    rq_valid = 1'b1; rq_kind = kind; rq_byp = byp; rq_tag = tag[TAG_W-1:0];
    @(negedge clk);
    rq_valid = 1'b0;
    chk(req, "dc_valid", int'(dc_valid), 1);
    chk(req, "dc_tag", int'(dc_tag), tag);
    chk(req, "dc_act", int'(dc_act), e_act);
  endtask

  task automatic t_reset;
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "dc_valid", int'(dc_valid), 0);
    chk("R1", "lk_ready", int'(lk_ready), 1);
    chk("R1", "rq_ready", int'(rq_ready), 1);
  endtask

  task automatic t_lookups;
    do_lk("R3", 5, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    do_lk("R3", 6, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    do_lk("R4", 7, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    do_lk("R2", 8, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    do_lk("R6", 9, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    do_lk("R2", 10, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    do_lk("R6", 11, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    do_lk("R4", 12, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    do_lk("R5", 13, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_requests;
    do_rq("R7", 20, 1'b0, 1'b0, 0);
    do_rq("R7", 21, 1'b0, 1'b1, 1);
    do_rq("R8", 22, 1'b1, 1'b1, 2);
    do_rq("R8", 23, 1'b1, 1'b0, 3);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    lk_valid = 1'b1; lk_op = 2'd2; lk_idx = 12'd40; lk_new = 1'b0; lk_rws = 1'b0; lk_dc_copy = 1'b1;
    rq_valid = 1'b1; rq_kind = 1'b1; rq_byp = 1'b1; rq_tag = 8'd41;
    @(negedge clk);
    lk_valid = 1'b0; rq_valid = 1'b0;
    chk("R2", "both rsp_rws", int'(rsp_rws), 1);
    chk("R6", "both rsp_inv_dc", int'(rsp_inv_dc), 1);
    chk("R8", "both dc_act", int'(dc_act), 2);
    chk("R8", "both dc_tag", int'(dc_tag), 41);
  endtask

  task automatic t_stall;
    @(negedge clk);
    rsp_ready = 1'b0;
    lk_valid = 1'b1; lk_op = 2'd0; lk_idx = 12'd50; lk_new = 1'b0; lk_rws = 1'b1; lk_dc_copy = 1'b0;
    @(negedge clk);
    lk_op = 2'd1; lk_idx = 12'd51; lk_rws = 1'b0; lk_dc_copy = 1'b1;
    chk("R9", "stall lk_ready", int'(lk_ready), 0);
    @(negedge clk);
    chk("R9", "held rsp_idx", int'(rsp_idx), 50);
    chk("R9", "held rsp_inv_dc", int'(rsp_inv_dc), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R9", "next rsp_idx", int'(rsp_idx), 51);
    chk("R9", "next rsp_inv_dc", int'(rsp_inv_dc), 1);
    @(negedge clk);
    chk("R9", "drained rsp_valid", int'(rsp_valid), 0);
  endtask

  initial begin
    #100us;
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_lookups;
    t_requests;
    t_same_cycle;
    t_stall;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule